// File: doc/BRIEF.md
# Five-Level Level-Shifted Carrier PWM Generator

This block drives the eight switch gates of one phase leg of a five-level diode-clamped inverter. It compares a signed, sampled reference against four digital triangular carriers and registers the resulting gate pattern. The carriers are stacked in four contiguous bands of equal height around zero.

All four carriers derive from one shared up/down count. A two-bit mode input sets how the carriers are phased against one another. In one mode the two inner carriers run at twice the rate of the outer ones. This spreads commutations more evenly across the switches.

The number of carriers that the reference lies strictly above gives one of five output levels. That level is decoded into the upper and lower gates of the leg. The carrier period and the mode are taken in only when the shared count is at zero, so a carrier never jumps part way through a period. Sine generation, dead time and the power stage lie outside this block.

Top module: `ls_pwm5`

## Requirements
- R1: While `rst_n` is low, `sw_hi` is 0000 and `sw_lo` is 1111, the shared count is 0 and the mode is 0.
- R2: The shared count c runs 0,1,…,P,P−1,…,1 and repeats, with period 2P clock cycles. Carrier j (j = 0 bottom to 3 top) equals (j−2)·P + t_j, where t_j lies in [0, P]. P is the period setting in effect.
- R3: The level k is the number of carriers that the reference is strictly greater than. `sw_hi[i]` (switch S(i+1)) is on exactly when i ≥ 4−k, so level 1 turns on only S4 (`sw_hi[3]`).
- R4: In mode 0 (all in phase), t_j = c for all four carriers.
- R5: In mode 1 (opposed halves), t_j = c for j = 2 and 3, and t_j = P−c for j = 0 and 1.
- R6: In mode 2 (alternating), t_j = c for j = 0 and 2, and t_j = P−c for j = 1 and 3.
- R7: In mode 3 (double-rate inner), t_j = c for j = 0 and 3. For j = 1 and 2, t_j = 2·min(c, P−c), which is a triangle at twice the carrier rate when P is even.
- R8: `mode_in` and `per_in` are sampled only on a clock edge at which the count is 0. A change while the count is nonzero has no effect until the next such edge.
- R9: The gates are registered. The value after a clock edge reflects the reference and the count present in the cycle before that edge.
- R10: `sw_lo` is always the bitwise complement of `sw_hi`, so exactly four of the eight switches are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | REF_W | Signed reference sample |
| mode_in | input | 2 | Carrier arrangement: 0 in phase, 1 opposed halves, 2 alternating, 3 double-rate inner |
| per_in | input | PER_W | Carrier half-period P in clock cycles, also the band height |
| sw_hi | output | 4 | Upper gates S1..S4, bit i is S(i+1) |
| sw_lo | output | 4 | Complementary gates S1'..S4' |

## Verification
A wrong count or a mode taken in mid-period shows up as a level that differs from the model at some edge within one carrier period, and usually within a few cycles, because the reference sweeps across every band. A wrong phase on any single carrier makes the level differ as soon as the reference enters that carrier's band. A broken gate decode shows on the very next edge as a non-thermometer `sw_hi` pattern or as `sw_lo` failing to complement it.

// File: rtl/ls_pwm5.sv
`timescale 1ns/1ps
module ls_pwm5 #(
  parameter int REF_W = 12,
  parameter int PER_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [1:0]              mode_in,
  input  logic [PER_W-1:0]        per_in,
  output logic [3:0]              sw_hi,
  output logic [3:0]              sw_lo
);
  localparam int CW = ((REF_W > PER_W + 2) ? REF_W : PER_W + 2) + 1;
  localparam logic [1:0] M_PD = 2'd0, M_POD = 2'd1, M_APOD = 2'd2, M_VF = 2'd3;

  logic [PER_W-1:0] cnt, per_q;
  logic             up;
  logic [1:0]       mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      per_q  <= '0;
      up     <= 1'b1;
      mode_q <= M_PD;
    end else if (cnt == '0) begin
      per_q  <= per_in;
      mode_q <= mode_in;
      cnt    <= {{(PER_W-1){1'b0}}, (per_in != '0)};
      up     <= per_in > PER_W'(1);
    end else if (up) begin
      cnt <= cnt + 1'b1;
      up  <= ({1'b0, cnt} + 1'b1) < {1'b0, per_q};
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  logic [PER_W-1:0]      inv;
  logic [PER_W:0]        dbl, ce, ie;
  logic signed [CW-1:0]  pext, rext;
  logic signed [CW-1:0]  edge_lo [4];
  logic signed [CW-1:0]  car [4];
  logic [PER_W:0]        tri_v [4];
  logic [3:0]            above;
  logic [2:0]            lvl;

  assign inv  = per_q - cnt;
  assign ce   = {1'b0, cnt};
  assign ie   = {1'b0, inv};
  assign dbl  = (cnt <= inv) ? {cnt, 1'b0} : {inv, 1'b0};
  assign pext = $signed({{(CW-PER_W){1'b0}}, per_q});
  assign rext = {{(CW-REF_W){ref_in[REF_W-1]}}, ref_in};

  assign edge_lo[0] = -(pext + pext);
  assign edge_lo[1] = -pext;
  assign edge_lo[2] = '0;
  assign edge_lo[3] = pext;

  always_comb begin
    for (int j = 0; j < 4; j++) begin
      case (mode_q)
        M_PD:    tri_v[j] = ce;
        M_POD:   tri_v[j] = (j >= 2) ? ce : ie;
        M_APOD:  tri_v[j] = (j % 2 == 1) ? ie : ce;
        default: tri_v[j] = (j == 1 || j == 2) ? dbl : ce;
      endcase
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_band
    assign car[g]   = edge_lo[g] + $signed({{(CW-PER_W-1){1'b0}}, tri_v[g]});
    assign above[g] = rext > car[g];
  end

  assign lvl = 3'($countones(above));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_hi <= 4'b0000;
      sw_lo <= 4'b1111;
    end else begin
      for (int i = 0; i < 4; i++) begin
        sw_hi[i] <= (i + int'(lvl)) >= 4;
        sw_lo[i] <= (i + int'(lvl)) < 4;
      end
    end
  end

  // R10
  pair_compl_chk: assert property (@(posedge clk) disable iff (!rst_n) sw_lo == ~sw_hi);
  // R3
  thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hi inside {4'b0000, 4'b1000, 4'b1100, 4'b1110, 4'b1111});
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> ($stable(mode_q) && $stable(per_q)));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= per_q);
endmodule

// File: tb/ls_pwm5_tb.sv
`timescale 1ns/1ps
module ls_pwm5_tb;
  localparam int REF_W = 12;
  localparam int PER_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [REF_W-1:0] ref_in = '0;
  logic [1:0] mode_in = 2'd0;
  logic [PER_W-1:0] per_in = '0;
  logic [3:0] sw_hi, sw_lo;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q [$];
  string tag_q [$];

  int m_ph = 0, m_p = 0, m_md = 0;

  always #2.5 clk = ~clk;

  ls_pwm5 #(.REF_W(REF_W), .PER_W(PER_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .mode_in(mode_in),
    .per_in(per_in), .sw_hi(sw_hi), .sw_lo(sw_lo));

  function automatic logic [3:0] exp_hi(int r, int c, int p, int md);
    int k = 0;
    logic [3:0] h;
    for (int j = 0; j < 4; j++) begin
      int t;
      int iv = p - c;
      int db = 2 * ((c < iv) ? c : iv);
      case (md)
        0: t = c;
        1: t = (j >= 2) ? c : iv;
        2: t = (j % 2 == 1) ? iv : c;
        default: t = (j == 1 || j == 2) ? db : c;
      endcase
      if (r > (j - 2) * p + t) k++;
    end
    for (int i = 0; i < 4; i++) h[i] = (i >= 4 - k);
    return h;
  endfunction

  function automatic string mode_tag(int md);
    case (md)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // driver: R2 R3 R9 expectations from the carrier model
  task automatic step(int r, int md, int p);
    int c;
    @(negedge clk);
    ref_in  = REF_W'(r);
    mode_in = 2'(md);
    per_in  = PER_W'(p);
    c = (m_ph <= m_p) ? m_ph : 2 * m_p - m_ph;
    exp_q.push_back(exp_hi(r, c, m_p, m_md));
    if (md != m_md && m_ph != 0) tag_q.push_back("R8");
    else tag_q.push_back(mode_tag(m_md));
    if (m_ph == 0) begin
      m_p  = p;
      m_md = md;
      m_ph = (m_p > 0) ? 1 : 0;
    end else begin
      m_ph = (m_ph + 1 == 2 * m_p) ? 0 : m_ph + 1;
    end
  endtask

  task automatic sweep(int n, int md, int p, int mul, int span);
    for (int i = 0; i < n; i++) step(((i * mul) % span) - span / 2, md, p);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (sw_hi !== e || sw_lo !== ~e) begin
        errors++;
        $display("FAIL %s/R3/R9/R10 hi=%b lo=%b expected hi=%b lo=%b", t, sw_hi, sw_lo, e, ~e);
      end
    end
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (sw_hi !== 4'b0000 || sw_lo !== 4'b1111) begin
      errors++;
      $display("FAIL R1 hi=%b lo=%b expected hi=0000 lo=1111", sw_hi, sw_lo);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;
    sweep(70, 0, 8, 7, 45);          // R4
    sweep(70, 1, 8, 7, 45);          // R5 (switch lands mid-period: R8)
    sweep(70, 2, 8, 11, 41);         // R6
    sweep(70, 3, 8, 5, 37);          // R7
    sweep(60, 0, 5, 3, 27);          // R2 odd period
    sweep(60, 3, 6, 7, 29);          // R7 second even period
    for (int i = 0; i < 20; i++) step(2047, 2, 8);   // R3 level 4
    for (int i = 0; i < 20; i++) step(-2048, 1, 8);  // R3 level 0
    for (int i = 0; i < 32; i++) step(i - 16, (i / 3) % 4, 8); // R8 rapid mode changes
    for (int i = 0; i < 34; i++) step((i % 2 == 0) ? 8 : -8, 2, (i < 17) ? 4 : 9); // R8 period change
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule